// File: doc/BRIEF.md
# Dual-Modulus Prescaler with Range Select

This block is a synchronous frequency divider for use ahead of the programmable counters in a synthesizer loop. It runs on the fast input signal, used directly as its clock. It produces a registered divided output whose period is either a base ratio or that ratio plus one input cycle. An outer swallow counter drives the modulus-control input to pick between the two ratios on a period-by-period basis. A second control input doubles the base ratio, which gives four ratios in total: B, B+1, 2B and 2B+1, where B is the parameter `BASE_RATIO`.

Each output period starts with a high phase. The extra input cycle of a plus-one period lengthens the high phase, and the low phase always lasts half the base ratio in use. Both control inputs are sampled once per period, on the cycle where a new high phase begins. A change during a period therefore affects only the next period. A one-cycle strobe marks the start of every period, so a swallow counter can step on it.

Top module: `dual_modulus_prescaler`

## Requirements
- R1: While `rst` is high at a rising clock edge, `divOut` and `periodStrobe` are low after that edge.
- R2: The first rising edge with `rst` low starts a period, and `divOut` and `periodStrobe` are both high after that edge.
- R3: A period that starts with `rangeSel`=1 and `modCtl`=1 lasts `BASE_RATIO` cycles. It has `BASE_RATIO/2` high cycles followed by `BASE_RATIO/2` low cycles (32/32 at the default of 64).
- R4: A period that starts with `rangeSel`=1 and `modCtl`=0 lasts `BASE_RATIO+1` cycles. It has `BASE_RATIO/2+1` high cycles and `BASE_RATIO/2` low cycles (33/32 by default).
- R5: A period that starts with `rangeSel`=0 and `modCtl`=1 lasts `2*BASE_RATIO` cycles, split evenly between high and low (64/64 by default).
- R6: A period that starts with `rangeSel`=0 and `modCtl`=0 lasts `2*BASE_RATIO+1` cycles. It has `BASE_RATIO+1` high cycles and `BASE_RATIO` low cycles (65/64 by default).
- R7: `rangeSel` and `modCtl` are sampled only at the edge that starts a period. Changes later in the period do not alter that period's phase lengths.
- R8: `periodStrobe` is high for exactly the first cycle of each high phase. `divOut` never rises without it.
- R9: Asserting `rst` during operation returns the block to the R1 state, and releasing it restarts as in R2.
- R10: With `BASE_RATIO`=32, the same encoding gives the ratios 32, 33, 64 and 65, with phases of 16/16, 17/16, 32/32 and 33/32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input signal to be divided, used as the clock |
| rst | input | 1 | Synchronous reset, active high |
| rangeSel | input | 1 | 1 selects base ratio B, 0 selects 2B |
| modCtl | input | 1 | 1 selects the plain ratio, 0 adds one cycle |
| divOut | output | 1 | Registered divided output, high phase first |
| periodStrobe | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The assertions assume that `rst` is held for at least one edge before normal operation starts. They assume nothing about when the control inputs move: the block's own sampling rule is what keeps each period consistent. The stimulus drives `rangeSel`, `modCtl` and `rst` only on falling edges. Mid-period changes of the controls come both from seeded random holds of random length and from a directed flip placed inside a high phase. A mid-run reset pulse is included. Every period is measured against the control values present at the edge that started it.

// File: rtl/prescaler_pkg.sv
`timescale 1ns/1ps
package prescaler_pkg;
  // Strobes from the phase control to the datapath.
  typedef struct packed {
    logic startPeriod;  // begin a new high phase and latch the ratio
    logic dropHigh;     // last high cycle: the output falls at this edge
  } phaseCtl_t;
endpackage

// File: rtl/prescaler_datapath.sv
`timescale 1ns/1ps
module prescaler_datapath
  import prescaler_pkg::*;
#(
  parameter int BASE_RATIO = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rangeSel,
  input  logic          modCtl,
  input  phaseCtl_t     ctl,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] highLen,
  output logic [CW-1:0] periodLen,
  output logic          running,
  output logic          divOut,
  output logic          periodStrobe
);
  localparam logic [CW-1:0] HALF_SHORT = CW'(BASE_RATIO / 2);
  localparam logic [CW-1:0] HALF_LONG  = CW'(BASE_RATIO);

  logic [CW-1:0] nextHalf;
  logic [CW-1:0] nextHigh;
  logic [CW-1:0] nextPeriod;

  // The ratio for the coming period comes from the live control inputs.
  // It is taken into the registers only when a period starts.
  always_comb begin
    nextHalf   = rangeSel ? HALF_SHORT : HALF_LONG;
    nextHigh   = nextHalf + {{(CW-1){1'b0}}, ~modCtl};
    nextPeriod = nextHalf + nextHigh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      highLen      <= HALF_SHORT;
      periodLen    <= HALF_SHORT + HALF_SHORT;
      running      <= 1'b0;
      divOut       <= 1'b0;
      periodStrobe <= 1'b0;
    end else begin
      running      <= 1'b1;
      periodStrobe <= ctl.startPeriod;
      if (ctl.startPeriod) begin
        cnt       <= '0;
        divOut    <= 1'b1;
        highLen   <= nextHigh;
        periodLen <= nextPeriod;
      end else begin
        cnt <= cnt + 1'b1;
        if (ctl.dropHigh) divOut <= 1'b0;
      end
    end
  end

  // R1: reset clears the output and the strobe.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!divOut && !periodStrobe));

  // R8: the strobe only marks high cycles.
  a_r8_strobe_in_high: assert property (@(posedge clk) disable iff (rst)
    periodStrobe |-> divOut);

  // R8: every rise of the output carries the strobe.
  a_r8_rise_marked: assert property (@(posedge clk) disable iff (rst)
    $rose(divOut) |-> periodStrobe);

  // R7: the latched ratio only moves where a period starts.
  a_r7_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !periodStrobe |-> ($stable(highLen) && $stable(periodLen)));

  // R4: the output falls after exactly the latched number of high cycles.
  a_r4_high_length: assert property (@(posedge clk) disable iff (rst)
    $fell(divOut) |-> (cnt == highLen));
endmodule

// File: rtl/prescaler_control.sv
`timescale 1ns/1ps
module prescaler_control
  import prescaler_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] highLen,
  input  logic [CW-1:0] periodLen,
  input  logic          running,
  output phaseCtl_t     ctl
);
  // A new period starts right after reset and when the counter reaches
  // the last cycle of the latched period.
  always_comb begin
    ctl.startPeriod = !running || (cnt == periodLen - CW'(1));
    ctl.dropHigh    = running && (cnt == highLen - CW'(1));
  end

  // R8: period starts never land on consecutive cycles.
  a_r8_single_start: assert property (@(posedge clk) disable iff (rst)
    ctl.startPeriod |=> !ctl.startPeriod);

  // R3: the counter stays inside the latched period.
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < periodLen));
endmodule

// File: rtl/dual_modulus_prescaler.sv
`timescale 1ns/1ps
module dual_modulus_prescaler
  import prescaler_pkg::*;
#(
  parameter int BASE_RATIO = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rangeSel,
  input  logic modCtl,
  output logic divOut,
  output logic periodStrobe
);
  localparam int CW = $clog2(2 * BASE_RATIO + 2);

  phaseCtl_t     ctl;
  logic [CW-1:0] cnt;
  logic [CW-1:0] highLen;
  logic [CW-1:0] periodLen;
  logic          running;

  prescaler_control #(.CW(CW)) i_control (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .highLen   (highLen),
    .periodLen (periodLen),
    .running   (running),
    .ctl       (ctl)
  );

  prescaler_datapath #(.BASE_RATIO(BASE_RATIO), .CW(CW)) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .rangeSel     (rangeSel),
    .modCtl       (modCtl),
    .ctl          (ctl),
    .cnt          (cnt),
    .highLen      (highLen),
    .periodLen    (periodLen),
    .running      (running),
    .divOut       (divOut),
    .periodStrobe (periodStrobe)
  );
endmodule

// File: tb/test_dual_modulus_prescaler.sv
`timescale 1ns/1ps
module prescaler_monitor #(
  parameter int    BASE = 64,
  parameter bit    SMALL = 1'b0,
  parameter string NAME = "main"
) (
  input  logic clk,
  input  logic rst,
  input  logic rangeSel,
  input  logic modCtl,
  input  logic divOut,
  input  logic periodStrobe,
  output int   checks,
  output int   fails
);
  bit    capRange, capMod, capRst;
  int    rel;
  bit    inPeriod;
  int    highCnt, lowCnt, expHigh, expLow;
  string cfgTag;

  initial begin
    checks = 0; fails = 0; inPeriod = 0; rel = 0; capRst = 1;
    highCnt = 0; lowCnt = 0; expHigh = 0; expLow = 0; cfgTag = "R3";
  end

  function automatic string tagFor(bit r, bit m);
    if (SMALL) return "R10";
    if (r && m) return "R3";
    if (r) return "R4";
    if (m) return "R5";
    return "R6";
  endfunction

  function automatic int halfFor(bit r);
    return r ? BASE / 2 : BASE;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", tag, NAME, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    capRange = rangeSel;
    capMod   = modCtl;
    capRst   = rst;
    if (rst) rel = 0;
    else     rel++;
  end

  always @(negedge clk) begin
    if (capRst) begin
      check(!divOut && !periodStrobe, "R1", "R9 output during reset",
            {divOut, periodStrobe}, 0);
      inPeriod = 0;
    end else if (periodStrobe) begin
      if (!inPeriod) begin
        check(rel == 1, "R2", "R9 first period start cycle", rel, 1);
      end else begin
        check(highCnt == expHigh, cfgTag, "R7 high phase length", highCnt, expHigh);
        check(lowCnt == expLow, cfgTag, "R7 low phase length", lowCnt, expLow);
      end
      check(divOut == 1'b1, "R8", "output high with strobe", divOut, 1);
      expLow   = halfFor(capRange);
      expHigh  = expLow + (capMod ? 0 : 1);
      cfgTag   = tagFor(capRange, capMod);
      highCnt  = 1;
      lowCnt   = 0;
      inPeriod = 1;
    end else if (!inPeriod) begin
      check(1'b0, "R2", "no period start after reset release", rel, 1);
    end else if (divOut) begin
      if (lowCnt != 0) check(1'b0, "R8", "output rose without strobe", 1, 0);
      highCnt++;
    end else begin
      lowCnt++;
      if (lowCnt == expLow + 1)
        check(1'b0, cfgTag, "low phase too long", lowCnt, expLow);
    end
  end
endmodule

module test_dual_modulus_prescaler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rangeSel = 1'b1;
  logic modCtl = 1'b1;
  logic divOut, periodStrobe;
  logic divOutS, periodStrobeS;
  int   checksA, failsA, checksB, failsB;
  int   wdBad = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  dual_modulus_prescaler #(.BASE_RATIO(64)) i_dual_modulus_prescaler (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .modCtl(modCtl),
    .divOut(divOut), .periodStrobe(periodStrobe)
  );

  dual_modulus_prescaler #(.BASE_RATIO(32)) i_dual_modulus_prescaler_small (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .modCtl(modCtl),
    .divOut(divOutS), .periodStrobe(periodStrobeS)
  );

  prescaler_monitor #(.BASE(64), .SMALL(1'b0), .NAME("base64")) i_monA (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .modCtl(modCtl),
    .divOut(divOut), .periodStrobe(periodStrobe),
    .checks(checksA), .fails(failsA)
  );

  prescaler_monitor #(.BASE(32), .SMALL(1'b1), .NAME("base32")) i_monB (
    .clk(clk), .rst(rst), .rangeSel(rangeSel), .modCtl(modCtl),
    .divOut(divOutS), .periodStrobe(periodStrobeS),
    .checks(checksB), .fails(failsB)
  );

  task automatic hold(bit r, bit m, int cycles);
    @(negedge clk);
    rangeSel = r;
    modCtl   = m;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d",
             checksA + checksB + wdBad, failsA + failsB + wdBad);
  endtask

  initial begin
    int seedDummy;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // Directed: each ratio held for several periods (R3, R4, R5, R6, R10).
    hold(1, 1, 300);
    hold(1, 0, 300);
    hold(0, 1, 400);
    hold(0, 0, 400);
    // R7: flip both controls in the middle of a high phase.
    hold(1, 1, 10);
    @(negedge clk);
    while (!periodStrobe) @(negedge clk);
    repeat (8) @(negedge clk);
    rangeSel = 1'b0;
    modCtl   = 1'b0;
    repeat (300) @(negedge clk);
    // Seeded random holds of random length.
    seedDummy = $urandom(32'd1995);
    for (int i = 0; i < 80; i++) begin
      hold(1'($urandom % 2), 1'($urandom % 2), 1 + ($urandom % 300));
    end
    // R9: reset in the middle of a period, then run again.
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    hold(1, 0, 400);
    hold(0, 1, 400);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      wdBad = 1;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule